// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when the processor leaves its current instruction stream to serve an interrupt or an exception. It also runs the fixed series of memory accesses that saves and restores the machine state. Three kinds of request compete for entry: an internally raised exception, a non-maskable line and a maskable line. The maskable line is gated by the interrupt-enable flag. A return request competes with them at the lowest priority. The datapath presents its current segment, pointer and flags values. Once a sequence completes, the datapath takes back the updated set through a one-cycle update strobe.

On entry the sequencer writes the saved state to the stack one 16-bit word at a time, each word at a pre-decremented stack pointer. It then clears the enable and trap flags. Next it reads a 32-bit handler entry from a 256-entry vector table, and that entry supplies the new code segment and instruction pointer. On return it reads the saved words back in the opposite order. Every access waits for the memory ready handshake.

Top module: `trap_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `upd_valid` and `acc_valid` are all low.
- R2: The maskable request is accepted only while bit 9 (interrupt enable) of `cur_flags` is 1. A rising edge on `nmi` is accepted whatever the flags hold.
- R3: Requests are sampled only while idle. The order is exception, then pending non-maskable, then enabled maskable, then return. `acc_valid` marks acceptance, with `acc_src` 0 = exception, 1 = non-maskable, 2 = maskable, 3 = return.
- R4: The non-maskable line is edge-triggered. Each rising edge produces one entry, an edge seen while busy is kept until idle, and a level held high produces no further entries.
- R5: Entry writes SS, the original SP, FLAGS, CS, IP, and then the error code only when `exc_has_err` was set with the exception. Before each write SP drops by 2, the address is {SS, SP} (SS in bits 31:16), and the word sits in `mem_wdata[15:0]`.
- R6: The pushed FLAGS word is the value before entry. The updated flags have bit 9 and bit 8 (trap) cleared and all other bits kept.
- R7: After the pushes, one read at address vector×4 loads CS from `mem_rdata[31:16]` and IP from `mem_rdata[15:0]`. The non-maskable vector is 2, the maskable vector is `intr_vec`, and the exception vector is `exc_vec`.
- R8: A return reads IP, CS, FLAGS, SP and SS at {SS, SP}, adding 2 after each read. No error code is read. The update carries the popped values, with SP equal to the popped SP.
- R9: Each access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle `mem_rdy` is high.
- R10: `busy` is high from the cycle after acceptance until the end of the cycle holding the single-cycle `upd_valid` pulse. `mem_req` and `upd_valid` stay low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, held until accepted |
| exc_vec | input | 8 | Exception vector number |
| exc_has_err | input | 1 | Exception supplies an error code |
| exc_err | input | 16 | Error code value |
| nmi | input | 1 | Non-maskable interrupt line (edge) |
| intr_req | input | 1 | Maskable interrupt request (level) |
| intr_vec | input | 8 | Maskable interrupt vector number |
| ret_req | input | 1 | Return request, held until accepted |
| acc_valid | output | 1 | A request is being accepted this cycle |
| acc_src | output | 2 | Source of the accepted request |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| cur_flags | input | 16 | Current flags |
| busy | output | 1 | Entry or return sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, word in low half |
| mem_rdy | input | 1 | Memory completes the access |
| mem_rdata | input | 32 | Read data |
| upd_valid | output | 1 | Updated state is valid (one cycle) |
| upd_cs | output | 16 | New code segment |
| upd_ip | output | 16 | New instruction pointer |
| upd_ss | output | 16 | New stack segment |
| upd_sp | output | 16 | New stack pointer |
| upd_flags | output | 16 | New flags |

## Verification
The hardest condition to reach is a collision. In it an exception, a fresh non-maskable edge and an enabled maskable request all arrive in the same idle cycle. The non-maskable edge must then survive a whole exception entry, and the maskable request must be blocked by the flags that entry cleared. It must then re-emerge when the later return restores the enable bit. The stimulus raises all three lines together, pulses the non-maskable line for one cycle only, and keeps the maskable line high through two nested returns. A random ready pattern stalls the accesses. The handler's error-code discard is modelled by raising `cur_sp` between the two returns.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [1:0] {
        SRC_EXC  = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_INTR = 2'd2,
        SRC_RET  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_POP,
        ST_DONE
    } st_e;

    // flag bit positions decoded by the datapath
    localparam int FLAG_TF = 8;
    localparam int FLAG_IF = 9;

    // fixed vector numbers
    localparam int VEC_DIVZ  = 0;
    localparam int VEC_NMI   = 2;
    localparam int VEC_STACK = 12;

    // step indices of the save and restore lists
    localparam int STEP_W       = 3;
    localparam int PUSH_FLAGS   = 2;
    localparam int PUSH_LAST    = 4;
    localparam int PUSH_LAST_EC = 5;
    localparam int POP_LAST     = 4;

endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_seq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             if_flag,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             nmi,
    input  logic             intr_req,
    input  logic [VEC_W-1:0] intr_vec,
    input  logic             ret_req,
    output logic             acc_valid,
    output src_e             acc_src,
    output logic [VEC_W-1:0] acc_vec
);

    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
    } arb_t;

    arb_t q, d;
    logic intr_ok;
    logic take_nmi;

    always_comb begin
        d        = q;
        intr_ok  = intr_req & if_flag;
        acc_src  = SRC_RET;
        acc_vec  = '0;
        if (exc_req) begin
            acc_src = SRC_EXC;
            acc_vec = exc_vec;
        end else if (q.nmi_pend) begin
            acc_src = SRC_NMI;
            acc_vec = VEC_W'(VEC_NMI);
        end else if (intr_ok) begin
            acc_src = SRC_INTR;
            acc_vec = intr_vec;
        end
        acc_valid  = idle & (exc_req | q.nmi_pend | intr_ok | ret_req);
        take_nmi   = acc_valid & (acc_src == SRC_NMI);
        d.nmi_prev = nmi;
        d.nmi_pend = (q.nmi_pend & ~take_nmi) | (nmi & ~q.nmi_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
    import trap_seq_pkg::*;
#(
    parameter int W     = 16,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  src_e             acc_src,
    input  logic [VEC_W-1:0] acc_vec,
    input  logic             exc_has_err,
    input  logic [W-1:0]     exc_err,
    input  logic [W-1:0]     cur_cs,
    input  logic [W-1:0]     cur_ip,
    input  logic [W-1:0]     cur_ss,
    input  logic [W-1:0]     cur_sp,
    input  logic [W-1:0]     cur_flags,
    input  logic             mem_rdy,
    input  logic [2*W-1:0]   mem_rdata,
    output logic             idle,
    output logic             mem_req,
    output logic             mem_we,
    output logic [2*W-1:0]   mem_addr,
    output logic [2*W-1:0]   mem_wdata,
    output logic             upd_valid,
    output logic [W-1:0]     upd_cs,
    output logic [W-1:0]     upd_ip,
    output logic [W-1:0]     upd_ss,
    output logic [W-1:0]     upd_sp,
    output logic [W-1:0]     upd_flags
);

    localparam int AW = 2 * W;
    localparam logic [W-1:0] CLR_MASK = W'((1 << FLAG_IF) | (1 << FLAG_TF));
    localparam logic [W-1:0] STEP_SZ  = W'(2);

    typedef struct packed {
        st_e               st;
        logic [STEP_W-1:0] step;
        logic              has_err;
        logic [W-1:0]      err;
        logic [VEC_W-1:0]  vec;
        logic [W-1:0]      cs;
        logic [W-1:0]      ip;
        logic [W-1:0]      ss;
        logic [W-1:0]      sp;
        logic [W-1:0]      fl;
        logic [W-1:0]      tsp;
    } ctl_t;

    ctl_t q, d;
    logic [STEP_W-1:0] last_push;
    logic [W-1:0]      sp_dn;
    logic [W-1:0]      sp_up;
    logic [W-1:0]      push_val;
    logic [W-1:0]      rd_lo;
    logic [W-1:0]      rd_hi;

    always_comb begin
        last_push = q.has_err ? STEP_W'(PUSH_LAST_EC) : STEP_W'(PUSH_LAST);
        sp_dn     = q.sp - STEP_SZ;
        sp_up     = q.sp + STEP_SZ;
        rd_lo     = mem_rdata[W-1:0];
        rd_hi     = mem_rdata[AW-1:W];
        case (q.step)
            3'd0:    push_val = q.ss;
            3'd1:    push_val = q.tsp;
            3'd2:    push_val = q.fl;
            3'd3:    push_val = q.cs;
            3'd4:    push_val = q.ip;
            default: push_val = q.err;
        endcase
    end

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        upd_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (acc_valid) begin
                    d.cs      = cur_cs;
                    d.ip      = cur_ip;
                    d.ss      = cur_ss;
                    d.sp      = cur_sp;
                    d.fl      = cur_flags;
                    d.tsp     = cur_sp;
                    d.vec     = acc_vec;
                    d.has_err = (acc_src == SRC_EXC) & exc_has_err;
                    d.err     = exc_err;
                    d.step    = '0;
                    d.st      = (acc_src == SRC_RET) ? ST_POP : ST_PUSH;
                end
            end
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.ss, sp_dn};
                mem_wdata = {{W{1'b0}}, push_val};
                if (mem_rdy) begin
                    d.sp = sp_dn;
                    if (q.step == STEP_W'(PUSH_FLAGS)) d.fl = q.fl & ~CLR_MASK;
                    if (q.step == last_push) d.st = ST_VEC;
                    else                     d.step = q.step + 1'b1;
                end
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = AW'({q.vec, 2'b00});
                if (mem_rdy) begin
                    d.cs = rd_hi;
                    d.ip = rd_lo;
                    d.st = ST_DONE;
                end
            end
            ST_POP: begin
                mem_req  = 1'b1;
                mem_addr = {q.ss, q.sp};
                if (mem_rdy) begin
                    d.sp = sp_up;
                    case (q.step)
                        3'd0:    d.ip  = rd_lo;
                        3'd1:    d.cs  = rd_lo;
                        3'd2:    d.fl  = rd_lo;
                        3'd3:    d.tsp = rd_lo;
                        default: begin
                            d.ss = rd_lo;
                            d.sp = q.tsp;
                        end
                    endcase
                    if (q.step == STEP_W'(POP_LAST)) d.st = ST_DONE;
                    else                             d.step = q.step + 1'b1;
                end
            end
            ST_DONE: begin
                upd_valid = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle      = (q.st == ST_IDLE);
    assign upd_cs    = q.cs;
    assign upd_ip    = q.ip;
    assign upd_ss    = q.ss;
    assign upd_sp    = q.sp;
    assign upd_flags = q.fl;

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int W     = 16,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             exc_has_err,
    input  logic [W-1:0]     exc_err,
    input  logic             nmi,
    input  logic             intr_req,
    input  logic [VEC_W-1:0] intr_vec,
    input  logic             ret_req,
    output logic             acc_valid,
    output logic [1:0]       acc_src,
    input  logic [W-1:0]     cur_cs,
    input  logic [W-1:0]     cur_ip,
    input  logic [W-1:0]     cur_ss,
    input  logic [W-1:0]     cur_sp,
    input  logic [W-1:0]     cur_flags,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [2*W-1:0]   mem_addr,
    output logic [2*W-1:0]   mem_wdata,
    input  logic             mem_rdy,
    input  logic [2*W-1:0]   mem_rdata,
    output logic             upd_valid,
    output logic [W-1:0]     upd_cs,
    output logic [W-1:0]     upd_ip,
    output logic [W-1:0]     upd_ss,
    output logic [W-1:0]     upd_sp,
    output logic [W-1:0]     upd_flags
);

    logic             idle;
    logic             arb_valid;
    src_e             arb_src;
    logic [VEC_W-1:0] arb_vec;

    trap_arb #(.VEC_W(VEC_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .if_flag   (cur_flags[FLAG_IF]),
        .exc_req   (exc_req),
        .exc_vec   (exc_vec),
        .nmi       (nmi),
        .intr_req  (intr_req),
        .intr_vec  (intr_vec),
        .ret_req   (ret_req),
        .acc_valid (arb_valid),
        .acc_src   (arb_src),
        .acc_vec   (arb_vec)
    );

    trap_ctl #(.W(W), .VEC_W(VEC_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (arb_valid),
        .acc_src     (arb_src),
        .acc_vec     (arb_vec),
        .exc_has_err (exc_has_err),
        .exc_err     (exc_err),
        .cur_cs      (cur_cs),
        .cur_ip      (cur_ip),
        .cur_ss      (cur_ss),
        .cur_sp      (cur_sp),
        .cur_flags   (cur_flags),
        .mem_rdy     (mem_rdy),
        .mem_rdata   (mem_rdata),
        .idle        (idle),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .upd_valid   (upd_valid),
        .upd_cs      (upd_cs),
        .upd_ip      (upd_ip),
        .upd_ss      (upd_ss),
        .upd_sp      (upd_sp),
        .upd_flags   (upd_flags)
    );

    assign acc_valid = arb_valid;
    assign acc_src   = arb_src;
    assign busy      = ~idle;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
    import trap_seq_pkg::*;
#(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           exc_req,
    input logic           acc_valid,
    input logic [1:0]     acc_src,
    input logic [W-1:0]   cur_flags,
    input logic           busy,
    input logic           mem_req,
    input logic           mem_we,
    input logic [2*W-1:0] mem_addr,
    input logic [2*W-1:0] mem_wdata,
    input logic           mem_rdy,
    input logic           upd_valid,
    input logic [W-1:0]   upd_flags
);

    logic in_entry_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                              in_entry_q <= 1'b0;
        else if (acc_valid)                      in_entry_q <= (acc_src != SRC_RET);
        else if (upd_valid)                      in_entry_q <= 1'b0;
    end

    AST_IF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_src == SRC_INTR |-> cur_flags[FLAG_IF]);                // R2

    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && exc_req |-> acc_src == SRC_EXC);                            // R3

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !busy);                                                   // R3

    AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && in_entry_q |-> upd_flags[FLAG_IF] == 1'b0 && upd_flags[FLAG_TF] == 1'b0); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

    AST_ACC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> busy);                                                    // R10

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid && !busy);                                     // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !upd_valid);                                      // R10

endmodule

bind trap_seq trap_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req   (exc_req),
    .acc_valid (acc_valid),
    .acc_src   (acc_src),
    .cur_flags (cur_flags),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdy   (mem_rdy),
    .upd_valid (upd_valid),
    .upd_flags (upd_flags)
);

// File: tb/sim_trap_seq.sv
module sim_trap_seq;
    import trap_seq_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        exc_req = 0, exc_has_err = 0, nmi = 0, intr_req = 0, ret_req = 0;
    logic [7:0]  exc_vec = 0, intr_vec = 0;
    logic [15:0] exc_err = 0;
    logic        acc_valid, busy, mem_req, mem_we, upd_valid;
    logic [1:0]  acc_src;
    logic [15:0] cur_cs = 16'h1234, cur_ip = 16'h0040, cur_ss = 16'h2000, cur_sp = 16'h0100, cur_flags = 16'h0002;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rdy = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] upd_cs, upd_ip, upd_ss, upd_sp, upd_flags;

    trap_seq u0 (.*);

    int n_run = 0, n_fail = 0;

    typedef struct {logic we; logic [31:0] addr; logic [15:0] data; string tag;} tx_t;
    typedef struct {logic [15:0] cs, ip, ss, sp, fl; bit entry;} st_t;

    tx_t  mem_q[$];
    st_t  upd_q[$];
    int   acc_q[$];
    st_t  frames[$];
    logic [31:0] mem [logic [31:0]];
    logic [15:0] m_cs = 16'h1234, m_ip = 16'h0040, m_ss = 16'h2000, m_sp = 16'h0100, m_fl = 16'h0002;
    bit   drop_exc = 0, drop_intr = 0, drop_ret = 0, prev_upd = 0;

    task automatic check(bit ok, string what, logic [79:0] act, logic [79:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_word(logic [31:0] idx);
        return {16'hC000 | idx[15:0], 16'h0100 + 16'(idx * 4)};
    endfunction

    function logic [31:0] model_rd(logic [31:0] a);
        if (a < 32'h400) return vec_word(a >> 2);
        if (mem.exists(a)) return mem[a];
        return 32'hDEAD_0000;
    endfunction

    // driver side: expected traffic for one entry (R5, R7)
    task automatic plan_entry(int src, int v, bit he, logic [15:0] err);
        st_t f;
        logic [15:0] s;
        f = '{m_cs, m_ip, m_ss, m_sp, m_fl, 1'b0};
        frames.push_back(f);
        s = m_sp;
        s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, m_ss, "R5 push SS"});
        s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, m_sp, "R5 push SP"});
        s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, m_fl, "R5 R6 push original FLAGS"});
        s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, m_cs, "R5 push CS"});
        s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, m_ip, "R5 push IP"});
        if (he) begin
            s -= 2; mem_q.push_back('{1'b1, {m_ss, s}, err, "R5 push error code"});
        end
        mem_q.push_back('{1'b0, 32'(v * 4), 16'h0, "R7 vector table read"});
        m_cs = 16'hC000 | 16'(v);
        m_ip = 16'h0100 + 16'(v * 4);
        m_sp = s;
        m_fl = m_fl & ~16'h0300;
        upd_q.push_back('{m_cs, m_ip, m_ss, m_sp, m_fl, 1'b1});
        acc_q.push_back(src);
    endtask

    // driver side: expected traffic for one return (R8)
    task automatic plan_return();
        st_t f;
        f = frames.pop_back();
        for (int i = 0; i < 5; i++)
            mem_q.push_back('{1'b0, {m_ss, m_sp + 16'(2 * i)}, 16'h0, "R8 pop read"});
        m_cs = f.cs; m_ip = f.ip; m_ss = f.ss; m_sp = f.sp; m_fl = f.fl;
        upd_q.push_back('{m_cs, m_ip, m_ss, m_sp, m_fl, 1'b0});
        acc_q.push_back(int'(SRC_RET));
    endtask

    // monitor, memory model and datapath model, all away from the rising edge
    always @(negedge clk) begin
        tx_t t;
        st_t e;
        int  s;
        logic r;
        if (rst_n) begin
            if (drop_exc)  exc_req  = 1'b0;
            if (drop_intr) intr_req = 1'b0;
            if (drop_ret)  ret_req  = 1'b0;
            drop_exc = 0; drop_intr = 0; drop_ret = 0;
            if (prev_upd)
                check(!upd_valid && !busy, "R10 update pulse then idle", {upd_valid, busy}, 0);
            prev_upd = upd_valid;
            r = ($urandom_range(0, 2) != 0);    // R9 random stalls
            mem_rdy   = r;
            mem_rdata = model_rd(mem_addr);
            if (mem_req && r) begin
                if (mem_q.size() == 0) begin
                    check(0, "R5 unexpected memory access", mem_addr, 0);
                end else begin
                    t = mem_q.pop_front();
                    check(mem_we == t.we && mem_addr == t.addr && (!t.we || mem_wdata == {16'h0, t.data}),
                          t.tag, {mem_we, mem_addr, mem_wdata}, {t.we, t.addr, 16'h0, t.data});
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
            end
            if (acc_valid) begin
                if (acc_q.size() == 0) begin
                    check(0, "R3 unexpected acceptance", acc_src, 0);
                end else begin
                    s = acc_q.pop_front();
                    check(acc_src == 2'(s), "R3 accepted source", acc_src, s);
                end
                drop_exc  = (acc_src == SRC_EXC);
                drop_intr = (acc_src == SRC_INTR);
                drop_ret  = (acc_src == SRC_RET);
            end
            if (upd_valid) begin
                if (upd_q.size() == 0) begin
                    check(0, "R10 unexpected update", upd_cs, 0);
                end else begin
                    e = upd_q.pop_front();
                    if (e.entry) begin
                        check(upd_cs == e.cs && upd_ip == e.ip, "R7 handler CS:IP", {upd_cs, upd_ip}, {e.cs, e.ip});
                        check(upd_flags == e.fl, "R6 flags after entry", upd_flags, e.fl);
                        check(upd_ss == e.ss && upd_sp == e.sp, "R5 SS:SP after pushes", {upd_ss, upd_sp}, {e.ss, e.sp});
                    end else begin
                        check({upd_cs, upd_ip, upd_ss, upd_sp, upd_flags} == {e.cs, e.ip, e.ss, e.sp, e.fl},
                              "R8 restored state", {upd_cs, upd_ip, upd_ss, upd_sp, upd_flags},
                              {e.cs, e.ip, e.ss, e.sp, e.fl});
                    end
                end
                cur_cs = upd_cs; cur_ip = upd_ip; cur_ss = upd_ss; cur_sp = upd_sp; cur_flags = upd_flags;
            end
        end
    end

    task automatic settle();
        @(negedge clk);
        while (mem_q.size() != 0 || upd_q.size() != 0 || acc_q.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_ret();
        @(posedge clk); #2;
        ret_req = 1'b1;
        settle();
    endtask

    task automatic quiet(int n, string what);
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (acc_valid || busy) bad = 1;
        end
        check(!bad, what, bad, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !upd_valid && !acc_valid, "R1 reset state",
              {busy, mem_req, upd_valid, acc_valid}, 0);

        // R2: maskable line ignored while enable flag is clear
        @(posedge clk); #2;
        intr_vec = 8'h20; intr_req = 1'b1;
        quiet(8, "R2 masked request ignored");

        // R2: enabling the flag lets it in; TF set too so R6 clears both
        plan_entry(int'(SRC_INTR), 8'h20, 0, 0);
        @(posedge clk); #2;
        cur_flags = 16'h0302; m_fl = 16'h0302;
        frames[frames.size() - 1].fl = 16'h0302;
        upd_q[upd_q.size() - 1].fl = 16'h0002;
        mem_q[2].data = 16'h0302;
        settle();
        plan_return();
        drive_ret();

        // divide error without error code, then return
        plan_entry(int'(SRC_EXC), VEC_DIVZ, 0, 0);
        @(posedge clk); #2;
        exc_vec = 8'(VEC_DIVZ); exc_has_err = 0; exc_req = 1'b1;
        settle();
        plan_return();
        drive_ret();

        // stack fault with error code; handler discards it before return
        plan_entry(int'(SRC_EXC), VEC_STACK, 1, 16'h00EE);
        @(posedge clk); #2;
        exc_vec = 8'(VEC_STACK); exc_has_err = 1; exc_err = 16'h00EE; exc_req = 1'b1;
        settle();
        @(posedge clk); #2;
        cur_sp = cur_sp + 16'd2; m_sp = m_sp + 16'd2;
        plan_return();
        drive_ret();

        // R2: non-maskable accepted with enable clear
        @(posedge clk); #2;
        cur_flags = 16'h0002; m_fl = 16'h0002;
        plan_entry(int'(SRC_NMI), VEC_NMI, 0, 0);
        @(posedge clk); #2; nmi = 1'b1;
        @(posedge clk); #2; nmi = 1'b0;
        settle();
        plan_return();
        drive_ret();

        // R4: a held level gives exactly one entry
        plan_entry(int'(SRC_NMI), VEC_NMI, 0, 0);
        @(posedge clk); #2; nmi = 1'b1;
        settle();
        plan_return();
        drive_ret();
        quiet(10, "R4 held NMI level not retaken");
        @(posedge clk); #2; nmi = 1'b0;

        // R3 and R4: exception, NMI edge and enabled maskable together
        @(posedge clk); #2;
        cur_flags = 16'h0202; m_fl = 16'h0202;
        plan_entry(int'(SRC_EXC), VEC_STACK, 1, 16'h0055);
        plan_entry(int'(SRC_NMI), VEC_NMI, 0, 0);
        @(posedge clk); #2;
        exc_vec = 8'(VEC_STACK); exc_has_err = 1; exc_err = 16'h0055; exc_req = 1'b1;
        nmi = 1'b1; intr_vec = 8'h31; intr_req = 1'b1;
        @(posedge clk); #2; nmi = 1'b0;
        settle();
        plan_return();
        drive_ret();
        @(posedge clk); #2;
        cur_sp = cur_sp + 16'd2; m_sp = m_sp + 16'd2;
        plan_return();
        plan_entry(int'(SRC_INTR), 8'h31, 0, 0);
        drive_ret();
        plan_return();
        drive_ret();
        check(cur_flags == 16'h0202 && cur_sp == 16'h0100, "R8 final state restored",
              {cur_flags, cur_sp}, {16'h0202, 16'h0100});

        finish_run();
    end

endmodule